// File: doc/BRIEF.md
# Write-Once Configuration Field Block

This block is a small APB slave that stores three configuration fields for a neighbouring peripheral: an 8-bit trim value, a 2-bit security mode and a 16-bit device ID. Each field can be written only once after reset. The first write that reaches a field is stored, and the same write closes that field. Every later write to that field is dropped without any error response. Only reset opens the field again. The three stored values are also driven on parallel outputs so the peripheral can use them directly.

Each field has its own one-way programmed flag. There is no separate lock register, no key sequence and no bus-level access check. The guard acts on every write that reaches the block, however legal that write is. A read-only status word reports which fields have been programmed, so software can see which fields are still open.

Top module: `wo_cfg_regs`

## Requirements
- R1: After reset, trim reads 0x00 at offset 0x0, security mode reads 0x0 at offset 0x4, device ID reads 0x0000 at offset 0x8, and the status word at offset 0xC reads 0.
- R2: The first write to a field after reset stores the field's low bits of PWDATA. A write counts only in the APB access phase, with PSEL, PENABLE and PWRITE all high. The field value and its programmed flag change together on that clock edge.
- R3: Once a field is programmed, every later write to it is discarded, and the field keeps its first value until the next reset.
- R4: A programmed flag only moves from 0 to 1. It is cleared only by PRESETn, and after reset each field again accepts one write.
- R5: A first write whose data equals the field's reset value still uses up the single permitted write and sets the programmed flag.
- R6: Reads always return the current field value, whether or not the field has been programmed. Status bit 0 is trim, bit 1 is mode and bit 2 is ID (1 = programmed). Status bits [31:3] read 0.
- R7: Writes to the status offset 0xC, to misaligned addresses and to offsets 0x10 and above change nothing. Reads of those undecoded addresses return 0.
- R8: PREADY is always 1 and PSLVERR is always 0, including for writes that are discarded.
- R9: A setup-phase cycle (PENABLE low) or a cycle with PSEL low does not commit a write or set a flag.
- R10: Fields are independent: writing one field leaves the value and the flag of every other field unchanged.
- R11: The parallel outputs cfg_trim, cfg_mode and cfg_id always equal the stored field values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (5) | Byte address |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| cfg_trim | output | TRIM_W (8) | Stored trim value |
| cfg_mode | output | MODE_W (2) | Stored security mode |
| cfg_id | output | ID_W (16) | Stored device ID |

## Verification
A programmed flag that is wrongly clear shows up at the ports on the clock edge of the next write to that field: the parallel output takes the second value, and a read returns it in the following access. A flag that is wrongly set shows up at once in the status word, and the field then refuses its first write. A fault in the access-phase qualification shows up as a committed value after a setup-only cycle. Each of these states therefore becomes visible within one or two bus transfers of the stimulus that exposes it.

// File: rtl/wo_cfg_regs.sv
module wo_cfg_regs #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int TRIM_W = 8,
  parameter int MODE_W = 2,
  parameter int ID_W   = 16,
  parameter logic [TRIM_W-1:0] TRIM_RST = '0,
  parameter logic [MODE_W-1:0] MODE_RST = '0,
  parameter logic [ID_W-1:0]   ID_RST   = '0
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [TRIM_W-1:0] cfg_trim,
  output logic [MODE_W-1:0] cfg_mode,
  output logic [ID_W-1:0]   cfg_id
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int NFLD  = 3;

  logic [TRIM_W-1:0] trim_q;
  logic [MODE_W-1:0] mode_q;
  logic [ID_W-1:0]   id_q;
  logic [NFLD-1:0]   done_q;

  logic             wr_acc, aligned;
  logic [IDX_W-1:0] word;
  logic             hit_trim, hit_mode, hit_id, hit_stat;

  assign wr_acc   = psel && penable && pwrite;
  assign aligned  = (paddr[1:0] == 2'b00);
  assign word     = paddr[ADDR_W-1:2];
  assign hit_trim = aligned && (word == IDX_W'(0));
  assign hit_mode = aligned && (word == IDX_W'(1));
  assign hit_id   = aligned && (word == IDX_W'(2));
  assign hit_stat = aligned && (word == IDX_W'(3));

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      trim_q <= TRIM_RST;
      mode_q <= MODE_RST;
      id_q   <= ID_RST;
      done_q <= '0;
    end else begin
      if (wr_acc && hit_trim && !done_q[0]) begin
        trim_q    <= pwdata[TRIM_W-1:0];
        done_q[0] <= 1'b1;
      end
      if (wr_acc && hit_mode && !done_q[1]) begin
        mode_q    <= pwdata[MODE_W-1:0];
        done_q[1] <= 1'b1;
      end
      if (wr_acc && hit_id && !done_q[2]) begin
        id_q      <= pwdata[ID_W-1:0];
        done_q[2] <= 1'b1;
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (hit_trim) prdata[TRIM_W-1:0] = trim_q;
    if (hit_mode) prdata[MODE_W-1:0] = mode_q;
    if (hit_id)   prdata[ID_W-1:0]   = id_q;
    if (hit_stat) prdata[NFLD-1:0]   = done_q;
  end

  assign pready   = 1'b1;
  assign pslverr  = 1'b0;
  assign cfg_trim = trim_q;
  assign cfg_mode = mode_q;
  assign cfg_id   = id_q;

  logic unused_wdata;
  assign unused_wdata = &{1'b0, pwdata[DATA_W-1:ID_W]};

  p_commit_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_acc && hit_trim && !done_q[0]) |=> (done_q[0] && cfg_trim == $past(pwdata[TRIM_W-1:0])));

  p_frozen_trim_r3: assert property (@(posedge pclk) disable iff (!presetn)
    done_q[0] |=> $stable(cfg_trim));
  p_frozen_mode_r3: assert property (@(posedge pclk) disable iff (!presetn)
    done_q[1] |=> $stable(cfg_mode));
  p_frozen_id_r3: assert property (@(posedge pclk) disable iff (!presetn)
    done_q[2] |=> $stable(cfg_id));

  p_oneway_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (done_q & $past(done_q)) == $past(done_q));

  p_noerr_r8: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);

  p_idle_r9: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_acc |=> ($stable(done_q) && $stable(cfg_trim) && $stable(cfg_mode) && $stable(cfg_id)));
endmodule

// File: tb/wo_cfg_regs_bench.sv
module wo_cfg_regs_bench;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  cfg_trim;
  logic [1:0]  cfg_mode;
  logic [15:0] cfg_id;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        rd_ev;

  always #10 pclk = ~pclk;

  wo_cfg_regs u_wo_cfg_regs (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .cfg_trim(cfg_trim), .cfg_mode(cfg_mode), .cfg_id(cfg_id));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
      else check(tag_q.pop_front(), prdata, exp_q.pop_front());
    end
  end

  task automatic apb_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic setup_only_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    psel = 1'b0; pwrite = 1'b0;
    penable = 1'b1;
    @(negedge pclk);
    penable = 1'b0;
  endtask

  task automatic apb_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #5;
    -> rd_ev;
    #1;
    check("R8 pready", {31'd0, pready}, 32'd1);
    check("R8 pslverr", {31'd0, pslverr}, 32'd0);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge pclk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    apb_read(5'h00, 32'h0, "R1 trim reset");
    apb_read(5'h04, 32'h0, "R1 mode reset");
    apb_read(5'h08, 32'h0, "R1 id reset");
    apb_read(5'h0C, 32'h0, "R1 status reset");

    apb_write(5'h00, 32'hFFFF_FF5A);
    check("R2 trim first write", {24'd0, cfg_trim}, 32'h5A);
    apb_read(5'h0C, 32'h1, "R6 status after trim");
    check("R10 mode untouched", {30'd0, cfg_mode}, 32'h0);
    apb_write(5'h00, 32'hA5);
    apb_read(5'h00, 32'h5A, "R3 trim second write dropped");
    check("R11 trim output", {24'd0, cfg_trim}, 32'h5A);

    apb_write(5'h04, 32'h0);
    apb_read(5'h0C, 32'h3, "R5 reset-value write programs mode");
    apb_write(5'h04, 32'h3);
    apb_read(5'h04, 32'h0, "R5 mode stays at first value");

    setup_only_write(5'h08, 32'hBEEF);
    apb_read(5'h0C, 32'h3, "R9 setup-only write ignored");
    apb_read(5'h08, 32'h0, "R6 unprogrammed id readable");
    apb_write(5'h08, 32'h1234);
    apb_write(5'h08, 32'hFFFF);
    apb_read(5'h08, 32'h1234, "R3 id holds first value");
    check("R11 id output", {16'd0, cfg_id}, 32'h1234);
    apb_read(5'h0C, 32'h7, "R4 all flags set");

    apb_write(5'h0C, 32'h0);
    apb_write(5'h10, 32'hFF);
    apb_write(5'h01, 32'hFF);
    apb_read(5'h0C, 32'h7, "R7 status write ignored");
    apb_read(5'h00, 32'h5A, "R7 undecoded writes leave trim");
    apb_read(5'h10, 32'h0, "R7 undecoded read zero");
    apb_read(5'h01, 32'h0, "R7 misaligned read zero");

    @(negedge pclk);
    presetn = 1'b0;
    @(negedge pclk);
    presetn = 1'b1;
    apb_read(5'h0C, 32'h0, "R4 reset clears flags");
    apb_read(5'h08, 32'h0, "R1 id back to reset");
    apb_write(5'h00, 32'h33);
    apb_write(5'h04, 32'h2);
    apb_read(5'h00, 32'h33, "R4 trim reopened");
    apb_read(5'h04, 32'h2, "R4 mode reopened");
    apb_read(5'h0C, 32'h3, "R10 id still open");

    #20;
    check("scoreboard drained", exp_q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule